// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the combinational arithmetic and logic stage of an integer execution unit. It takes two 32-bit operands, a 4-bit operation code and the current carry flag. It returns a 32-bit result, a write-enable for the destination register, five new flag values and a five-bit mask. The mask tells the flag register, which sits outside the block, which flags to overwrite.

Each operation follows its own flag policy:
- The carry-in forms fold the incoming carry into the sum or the borrow.
- Compare and test set the flags but do not write a result.
- Increment and decrement leave the carry flag alone.
- Negate raises carry for every non-zero operand.
- The bitwise inversion touches no flag at all.

The surrounding pipeline registers the outputs. The block itself holds no state.

Top module: `int_alu_flags`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, NEG=4, INC=5, DEC=6, CMP=7, AND=8, OR=9, XOR=10, NOT=11, TEST=12. Codes 13 to 15 give result 0, write-enable 0 and flag mask 0. The write-enable is 1 for every defined code except CMP and TEST.
- R2: ADD returns a+b and ADC returns a+b+carry_in, both modulo 2^32. The new CF is the unsigned carry out of bit 31.
- R3: SUB returns a-b and SBB returns a-(b+carry_in), both modulo 2^32. The new CF is 1 exactly when that difference is negative as an unsigned quantity, i.e. it signals a borrow.
- R4: OF is 1 exactly when the two's-complement result of ADD, ADC, SUB, SBB, NEG, INC, DEC or CMP lies outside the signed 32-bit range.
- R5: NEG returns 0-a. Its CF is 0 when a is zero and 1 otherwise.
- R6: INC returns a+1 and DEC returns a-1. The CF mask bit is 0; the other four mask bits are 1.
- R7: CMP drives the result port with a-b and updates all five flags as SUB does, but does not write the result.
- R8: AND, OR and XOR return the bitwise function of a and b. TEST drives a AND b and does not write it. All four update all five flags, with CF=0 and OF=0.
- R9: NOT returns the bitwise inverse of a, writes it, and has flag mask 0.
- R10: ZF is 1 when all 32 result bits are zero. SF equals result bit 31. PF is 1 when bits 7:0 of the result hold an even number of ones.
- R11: The flag vectors are ordered [0]=CF, [1]=PF, [2]=ZF, [3]=SF, [4]=OF. The CF, PF, ZF, SF and OF values listed in R2 to R10 appear in `flag_val` at every bit where `flag_upd` is 1 for that operation. A `flag_val` bit whose mask bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | Destination-side operand |
| opd_b | input | 32 | Source-side operand |
| op_code | input | 4 | Operation select, encoding per R1 |
| carry_in | input | 1 | Current carry flag |
| res | output | 32 | Operation result |
| res_we | output | 1 | Result write-enable |
| flag_val | output | 5 | New flag values, order per R11 |
| flag_upd | output | 5 | Per-flag update mask, order per R11 |

## Verification
The block has no internal state, so any fault in the datapath shows up at the outputs in the same cycle as the input vector that triggers it. A fault in the carry or overflow inversion for the subtract forms appears only when operand magnitudes cross the unsigned or signed boundary. A wrong mask decode only shows in the operations that leave flags alone (INC, DEC, NOT) or discard the result (CMP, TEST). The directed corners therefore cover zero, all ones and the most negative value under every operation, with carry_in at both levels. Seeded random vectors are added on top of these corners.

// File: rtl/ialu_pkg.sv
// Package: operation encoding and flag bit positions shared by the ALU
// modules. Assumes a 4-bit operation code.
package ialu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_NEG  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_CMP  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11,
        OP_TEST = 4'd12
    } alu_op_e;

    localparam int NUM_FLAGS = 5;
    localparam int FLG_CF    = 0;
    localparam int FLG_PF    = 1;
    localparam int FLG_ZF    = 2;
    localparam int FLG_SF    = 3;
    localparam int FLG_OF    = 4;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/alu_addsub.sv
// Module: shared adder/subtractor. When subtracting, it inverts b and
// the carry-in, so one carry chain serves every add and subtract form.
// Assumes that borrow_in is a raw carry flag (1 means take one more away).
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         extra_in,
    output logic [W-1:0] sum,
    output logic         cf,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   wide;

    // Form the effective addend and carry, then add.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~extra_in : extra_in;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum   = wide[W-1:0];
        cf    = sub ? ~wide[W] : wide[W];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
// Module: bitwise unit, one cell per bit built with generate.
// Assumes that fn selects AND, OR, XOR or the inversion of a.
module alu_logic
    import ialu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit function select.
        always_comb begin
            unique case (fn)
                LG_AND:  y[i] = a[i] & b[i];
                LG_OR:   y[i] = a[i] | b[i];
                LG_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = ~a[i];
            endcase
        end
    end
endmodule

// File: rtl/alu_flag_gen.sv
// Module: result-derived flags (zero, sign, parity of the low PB bits).
// Assumes PB <= W.
module alu_flag_gen #(
    parameter int W  = 32,
    parameter int PB = 8
) (
    input  logic [W-1:0] r,
    output logic         zf,
    output logic         sf,
    output logic         pf
);
    // Reduce the result to its three shape flags.
    always_comb begin
        zf = ~|r;
        sf = r[W-1];
        pf = ~^r[PB-1:0];
    end
endmodule

// File: rtl/int_alu_flags.sv
// Module: top of the integer ALU. It decodes the operation, steers the
// operands into the adder or the logic unit, and assembles the result,
// the write-enable, the flag values and the flag mask.
// Assumes that a register outside the block holds the flags and applies
// the mask. The block itself is purely combinational.
module int_alu_flags
    import ialu_pkg::*;
#(
    parameter int W  = 32,
    parameter int PB = 8
) (
    input  logic [W-1:0]         opd_a,
    input  logic [W-1:0]         opd_b,
    input  logic [3:0]           op_code,
    input  logic                 carry_in,
    output logic [W-1:0]         res,
    output logic                 res_we,
    output logic [NUM_FLAGS-1:0] flag_val,
    output logic [NUM_FLAGS-1:0] flag_upd
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    alu_op_e      op;
    logic [W-1:0] add_a, add_b, add_sum, lg_y, r_sel;
    logic         add_sub, add_xin, add_cf, add_of;
    logic         use_logic, known;
    logic_fn_e    lg_fn;
    logic         zf, sf, pf;

    assign op = alu_op_e'(op_code);

    // Steer operands and controls into the adder.
    always_comb begin
        add_a   = opd_a;
        add_b   = opd_b;
        add_sub = 1'b0;
        add_xin = 1'b0;
        case (op)
            OP_ADC:                 add_xin = carry_in;
            OP_SUB, OP_CMP:         add_sub = 1'b1;
            OP_SBB: begin           add_sub = 1'b1; add_xin = carry_in; end
            OP_NEG: begin           add_a = '0; add_b = opd_a; add_sub = 1'b1; end
            OP_INC:                 add_b = ONE;
            OP_DEC: begin           add_b = ONE; add_sub = 1'b1; end
            default: ;
        endcase
    end

    // Choose the logic function and the unit that drives the result.
    always_comb begin
        use_logic = 1'b0;
        known     = 1'b1;
        lg_fn     = LG_AND;
        case (op)
            OP_AND, OP_TEST: use_logic = 1'b1;
            OP_OR:  begin use_logic = 1'b1; lg_fn = LG_OR;  end
            OP_XOR: begin use_logic = 1'b1; lg_fn = LG_XOR; end
            OP_NOT: begin use_logic = 1'b1; lg_fn = LG_NOT; end
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG,
            OP_INC, OP_DEC, OP_CMP: ;
            default: known = 1'b0;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a(add_a), .b(add_b), .sub(add_sub), .extra_in(add_xin),
        .sum(add_sum), .cf(add_cf), .ovf(add_of)
    );

    alu_logic #(.W(W)) u_logic (
        .a(opd_a), .b(opd_b), .fn(lg_fn), .y(lg_y)
    );

    // Result mux; undefined codes produce zero.
    always_comb begin
        if (!known)        r_sel = '0;
        else if (use_logic) r_sel = lg_y;
        else               r_sel = add_sum;
    end

    alu_flag_gen #(.W(W), .PB(PB)) u_flags (
        .r(r_sel), .zf(zf), .sf(sf), .pf(pf)
    );

    // Write-enable, mask and flag values per operation.
    always_comb begin
        res      = r_sel;
        res_we   = known && (op != OP_CMP) && (op != OP_TEST);
        flag_upd = '0;
        if (known && op != OP_NOT) begin
            flag_upd = '1;
            if (op == OP_INC || op == OP_DEC) flag_upd[FLG_CF] = 1'b0;
        end
        flag_val         = '0;
        flag_val[FLG_CF] = use_logic ? 1'b0 : add_cf;
        flag_val[FLG_OF] = use_logic ? 1'b0 : add_of;
        flag_val[FLG_ZF] = zf;
        flag_val[FLG_SF] = sf;
        flag_val[FLG_PF] = pf;
        flag_val         = flag_val & flag_upd;
    end

    // Checks relating the decode, the adder and the flag generator.
    always_comb begin
        AST_DISCARD_CMP: assert (!(op == OP_CMP && res_we)) else $error("CMP wrote"); // R7
        AST_DISCARD_TEST: assert (!(op == OP_TEST && res_we)) else $error("TEST wrote"); // R8
        AST_KEEP_CARRY: assert (!((op == OP_INC || op == OP_DEC) && flag_upd[FLG_CF])) else $error("INC/DEC touched CF"); // R6
        AST_NOT_SILENT: assert (!(op == OP_NOT && flag_upd != '0)) else $error("NOT touched flags"); // R9
        AST_NEG_CARRY: assert (!(op == OP_NEG && flag_val[FLG_CF] != (opd_a != '0))) else $error("NEG CF"); // R5
        AST_LOGIC_CLEAR: assert (!(use_logic && (flag_val[FLG_CF] || flag_val[FLG_OF]))) else $error("logic CF/OF"); // R8
        AST_ZERO_FLAG: assert (!(flag_upd[FLG_ZF] && flag_val[FLG_ZF] != (res == '0))) else $error("ZF"); // R10
        AST_UNUSED_CODE: assert (known || (flag_upd == '0 && !res_we)) else $error("undefined code acted"); // R1
    end
endmodule

// File: tb/tb_int_alu_flags.sv
module tb_int_alu_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opd_a, opd_b, res;
    logic [3:0]  op_code;
    logic        carry_in, res_we;
    logic [4:0]  flag_val, flag_upd;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    int_alu_flags dut (
        .opd_a(opd_a), .opd_b(opd_b), .op_code(op_code), .carry_in(carry_in),
        .res(res), .res_we(res_we), .flag_val(flag_val), .flag_upd(flag_upd)
    );

    // Expected model built from the requirement text.
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [3:0] op, input logic ci,
                                  output logic [31:0] r, output logic we,
                                  output logic [4:0] fv, output logic [4:0] fm);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint sres = 0;
        logic   cf = 1'b0;
        logic   arith = 1'b1;
        r = 32'd0; we = 1'b1; fm = 5'b11111;
        case (op)
            4'd0: begin r = a + b; cf = ({1'b0, a} + {1'b0, b}) > 33'hFFFFFFFF; sres = sa + sb; end
            4'd1: begin r = a + b + {31'd0, ci}; cf = ({1'b0, a} + {1'b0, b} + {32'd0, ci}) > 33'hFFFFFFFF; sres = sa + sb + longint'(ci); end
            4'd2, 4'd7: begin r = a - b; cf = a < b; sres = sa - sb; we = (op == 4'd2); end
            4'd3: begin r = a - b - {31'd0, ci}; cf = {1'b0, a} < ({1'b0, b} + {32'd0, ci}); sres = sa - sb - longint'(ci); end
            4'd4: begin r = 32'd0 - a; cf = (a != 0); sres = -sa; end
            4'd5: begin r = a + 1; sres = sa + 1; fm = 5'b11110; end
            4'd6: begin r = a - 1; sres = sa - 1; fm = 5'b11110; end
            4'd8, 4'd12: begin r = a & b; arith = 1'b0; we = (op == 4'd8); end
            4'd9:  begin r = a | b; arith = 1'b0; end
            4'd10: begin r = a ^ b; arith = 1'b0; end
            4'd11: begin r = ~a; arith = 1'b0; fm = 5'b00000; end
            default: begin we = 1'b0; fm = 5'b00000; arith = 1'b0; end
        endcase
        fv[0] = arith ? cf : 1'b0;
        fv[1] = ($countones(r[7:0]) % 2) == 0;
        fv[2] = (r == 32'd0);
        fv[3] = r[31];
        fv[4] = arith ? (sres > 64'sd2147483647 || sres < -64'sd2147483648) : 1'b0;
        fv = fv & fm;
    endfunction

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4: return "R5";
            4'd5, 4'd6: return "R6";
            4'd7: return "R7";
            4'd8, 4'd9, 4'd10, 4'd12: return "R8";
            4'd11: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one vector after a rising edge, compare at the falling edge.
    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op, input logic ci);
        logic [31:0] er; logic ew; logic [4:0] ev, em;
        @(posedge clk); #1;
        opd_a = a; opd_b = b; op_code = op; carry_in = ci;
        @(negedge clk);
        model(a, b, op, ci, er, ew, ev, em);
        chk(tag(op), "result", res, er);
        chk(op inside {4'd7, 4'd12, 4'd13} ? "R1" : tag(op), "write", {31'd0, res_we}, {31'd0, ew});
        chk("R11", "mask", {27'd0, flag_upd}, {27'd0, em});
        chk((op <= 4'd7) ? "R4" : "R10", "flags", {27'd0, flag_val}, {27'd0, ev});
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner [6] = '{32'h0, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'h1, 32'h000000FF};
        void'($urandom(32'd20240607));
        opd_a = 0; opd_b = 0; op_code = 4'd0; carry_in = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R2 reset-time output: ADD of zeros gives zero with ZF and PF set.
        @(negedge clk);
        chk("R10", "idle result", res, 32'd0);
        chk("R10", "idle flags", {27'd0, flag_val}, 32'h6);
        // Directed corners: every code on boundary operand pairs, both carries.
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j += 5)
                    for (int c = 0; c < 2; c++)
                        run(corner[i], corner[j == 0 ? i : (i + 1) % 6], 4'(op), 1'(c));
        // R3 SBB with b all ones and carry set: borrow, no overflow.
        run(32'h5, 32'hFFFFFFFF, 4'd3, 1'b1);
        // R5 NEG of most negative value overflows.
        run(32'h80000000, 32'h0, 4'd4, 1'b0);
        // Seeded random vectors across all codes.
        for (int k = 0; k < 2000; k++)
            run($urandom, ($urandom % 4 == 0) ? $urandom % 4 : $urandom, 4'($urandom % 16), 1'($urandom));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule